// File: doc/BRIEF.md
# SDRAM Bank Precharge Scheduler

This block follows the state of a single SDRAM bank and works out, clock by clock, whether a precharge may be sent to that bank. It watches the activate, read and write strobes that a controller issues. It times the minimum row-open interval from the activate. It also places the earliest legal precharge relative to the clock on which the last burst word is on the data bus. For reads that point is moved earlier by a lead that depends on the CAS latency. For writes it is moved later by the write-recovery count.

A controller raises `pre_req` whenever it wants the row closed. The block turns that request into a single-cycle `pre_cmd` on the first clock where closing is legal, and keeps the request pending if it arrives too early. After the precharge it counts the precharge time before `bank_idle` reports that a new activate will be taken. Every timing value is a clock count given on a configuration input and is captured when the command that uses it is accepted.

Top module: `sdram_pre_sched`

## Requirements
- R1: After an accepted activate in cycle A, `pre_ok` stays low in every cycle before A + max(`cfg_tras`, 1).
- R2: When no read or write has been accepted since the activate, only the row-open time of R1 gates `pre_ok`.
- R3: With `cfg_cl` = 2, a read accepted in cycle T has its last word in cycle T + 2 + BL − 1. The earliest precharge is one clock before that word, so `pre_ok` may be high from cycle T + BL.
- R4: Any `cfg_cl` value other than 2 is taken as CAS latency 3. A read then has its last word in cycle T + 3 + BL − 1, and the earliest precharge is two clocks before it. That point, T + BL, still leaves every burst word on the bus.
- R5: A write accepted in cycle T has its last word in cycle T + BL − 1, and `pre_ok` may be high from cycle T + max(BL − 1 + `cfg_tdpl`, 1).
- R6: Burst length BL is 1, 2, 4 or 8 for `cfg_bl` codes 0, 1, 2 and 3.
- R7: `pre_ok` is high exactly when the row is open and both the R1 condition and the burst/recovery condition hold. `pre_cmd` is a one-cycle pulse in a cycle where `pre_ok` is high, a request is present or pending, and no read or write is presented. `pre_req` while no row is open has no effect.
- R8: A `pre_req` made while `pre_ok` is low is held, and `pre_cmd` fires on the first later cycle where R7 allows it, even if `pre_req` has since dropped.
- R9: After `pre_cmd` in cycle P, `row_open` is low from cycle P + 1, and `bank_idle` stays low until cycle P + max(`cfg_trp`, 1). An activate before then is ignored.
- R10: An activate is accepted only in a cycle where `bank_idle` is high. Reads and writes are ignored unless `row_open` is high.
- R11: A synchronous active-high `rst` makes `bank_idle` high and `row_open`, `pre_ok` and `pre_cmd` low from the next cycle.
- R12: Each accepted read or write restarts the burst/recovery window, so the latest command decides the earliest precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act | input | 1 | Activate strobe |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| pre_req | input | 1 | Request to close the row |
| cfg_cl | input | 2 | CAS latency (2, otherwise 3) |
| cfg_bl | input | 2 | Burst length code: 0→1, 1→2, 2→4, 3→8 |
| cfg_tras | input | CNT_W | Minimum row-open time in clocks |
| cfg_trp | input | CNT_W | Precharge time in clocks |
| cfg_tdpl | input | CNT_W | Write-recovery time in clocks, rounded up |
| pre_ok | output | 1 | A precharge is legal this cycle |
| pre_cmd | output | 1 | Precharge command pulse |
| bank_idle | output | 1 | Bank idle; an activate will be taken |
| row_open | output | 1 | Row is open |

## Verification
The assertions assume that the controller never presents a read and a write in the same cycle. They also assume that `cfg_tras` only changes while no row is open, because the row-open check compares the current setting with the clocks counted since the activate. The random phase of the bench draws read and write as one exclusive choice. It changes the configuration only in cycles where `bank_idle` is high, so both assumptions hold. The directed phase uses fixed configurations and reaches the read, write, held-request and restart corners at hand-computed cycles.

// File: rtl/sdram_pre_sched.sv
module sdram_pre_sched #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic             rd,
  input  logic             wr,
  input  logic             pre_req,
  input  logic [1:0]       cfg_cl,
  input  logic [1:0]       cfg_bl,
  input  logic [CNT_W-1:0] cfg_tras,
  input  logic [CNT_W-1:0] cfg_trp,
  input  logic [CNT_W-1:0] cfg_tdpl,
  output logic             pre_ok,
  output logic             pre_cmd,
  output logic             bank_idle,
  output logic             row_open
);
  localparam int DW = CNT_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_OPEN, S_PRE} st_t;

  st_t              st;
  logic [CNT_W-1:0] ras_cnt, rp_cnt;
  logic [DW-1:0]    bst_cnt;
  logic             pend;

  logic [DW-1:0] bl_w, cl_w, lead_w, rd_gap, wr_gap, gap, gap_ld;

  assign bl_w   = DW'(4'd1 << cfg_bl);
  assign cl_w   = (cfg_cl == 2'd2) ? DW'(2) : DW'(3);
  assign lead_w = cl_w - DW'(1);
  assign rd_gap = cl_w + bl_w - DW'(1) - lead_w;
  assign wr_gap = bl_w - DW'(1) + DW'(cfg_tdpl);
  assign gap    = wr ? wr_gap : rd_gap;
  assign gap_ld = (gap == '0) ? '0 : gap - DW'(1);

  assign row_open  = (st == S_OPEN);
  assign bank_idle = (st == S_IDLE) || (st == S_PRE && rp_cnt == '0);
  assign pre_ok    = row_open && ras_cnt == '0 && bst_cnt == '0;
  assign pre_cmd   = pre_ok && (pre_req || pend) && !rd && !wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      ras_cnt <= '0;
      rp_cnt  <= '0;
      bst_cnt <= '0;
      pend    <= 1'b0;
    end else begin
      if (bank_idle) begin
        if (act) begin
          st      <= S_OPEN;
          ras_cnt <= (cfg_tras == '0) ? '0 : cfg_tras - 1'b1;
          bst_cnt <= '0;
          pend    <= 1'b0;
        end else begin
          st <= S_IDLE;
        end
      end else if (st == S_PRE) begin
        rp_cnt <= rp_cnt - 1'b1;
      end else if (st == S_OPEN) begin
        if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
        if (pre_cmd) begin
          st     <= S_PRE;
          rp_cnt <= (cfg_trp == '0) ? '0 : cfg_trp - 1'b1;
          pend   <= 1'b0;
        end else begin
          if (rd || wr)           bst_cnt <= gap_ld;
          else if (bst_cnt != '0) bst_cnt <= bst_cnt - 1'b1;
          if (pre_req) pend <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_pre_sched_chk.sv
module sdram_pre_sched_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             act,
  input logic [CNT_W-1:0] cfg_tras,
  input logic             pre_ok,
  input logic             pre_cmd,
  input logic             bank_idle,
  input logic             row_open
);
  logic [CNT_W:0] since_act;

  always_ff @(posedge clk) begin
    if (rst)                  since_act <= '0;
    else if (act && bank_idle) since_act <= (CNT_W+1)'(1);
    else if (since_act != '1)  since_act <= since_act + 1'b1;
  end

  a_r7_cmd_needs_ok: assert property (@(posedge clk) disable iff (rst)
    pre_cmd |-> pre_ok && row_open);

  a_r7_cmd_single: assert property (@(posedge clk) disable iff (rst)
    pre_cmd |=> !pre_cmd);

  a_r9_closed_after_cmd: assert property (@(posedge clk) disable iff (rst)
    pre_cmd |=> !row_open && !pre_ok);

  a_r10_open_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(row_open) |-> $past(act && bank_idle));

  a_r1_ras_met: assert property (@(posedge clk) disable iff (rst)
    pre_ok |-> since_act >= (CNT_W+1)'(cfg_tras) && since_act != '0);

  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> bank_idle && !row_open && !pre_cmd);

  always_comb begin
    if (!rst) a_r10_idle_excl: assert (!(bank_idle && row_open));
  end
endmodule

bind sdram_pre_sched sdram_pre_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .act(act), .cfg_tras(cfg_tras),
  .pre_ok(pre_ok), .pre_cmd(pre_cmd), .bank_idle(bank_idle), .row_open(row_open)
);

// File: tb/sdram_pre_sched_bench.sv
`timescale 1ns/1ps
module sdram_pre_sched_bench;
  localparam int CNT_W = 8;

  logic clk = 0, rst = 1, act = 0, rd = 0, wr = 0, pre_req = 0;
  logic [1:0] cfg_cl = 2, cfg_bl = 2;
  logic [CNT_W-1:0] cfg_tras = 3, cfg_trp = 2, cfg_tdpl = 2;
  logic pre_ok, pre_cmd, bank_idle, row_open;

  always #2.5 clk = ~clk;

  sdram_pre_sched #(.CNT_W(CNT_W)) u_sdram_pre_sched (
    .clk(clk), .rst(rst), .act(act), .rd(rd), .wr(wr), .pre_req(pre_req),
    .cfg_cl(cfg_cl), .cfg_bl(cfg_bl), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
    .cfg_tdpl(cfg_tdpl), .pre_ok(pre_ok), .pre_cmd(pre_cmd),
    .bank_idle(bank_idle), .row_open(row_open)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic check(string tag, int act_v, int exp_v);
    n_vec++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // reference model: 0 idle, 1 open, 2 precharging
  int cyc = 0, m_st = 0, ras_at = 0, bst_at = 0, idle_at = 0;
  bit m_pend = 0, m_live = 0;

  function automatic int mx1(int v); return (v < 1) ? 1 : v; endfunction
  function automatic int bl_n(); return 1 << cfg_bl; endfunction
  function automatic int cl_n(); return (cfg_cl == 2) ? 2 : 3; endfunction
  function automatic bit e_open(); return m_st == 1; endfunction
  function automatic bit e_ok();
    return e_open() && cyc >= ras_at && cyc >= bst_at;
  endfunction
  function automatic bit e_cmd();
    return e_ok() && (pre_req || m_pend) && !rd && !wr;
  endfunction
  function automatic bit e_idle();
    return m_st == 0 || (m_st == 2 && cyc >= idle_at);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_pend = 0;
    end else if (e_idle()) begin
      if (act) begin
        m_st = 1; ras_at = cyc + mx1(int'(cfg_tras)); bst_at = 0; m_pend = 0;
      end else m_st = 0;
    end else if (m_st == 1) begin
      if (e_cmd()) begin
        m_st = 2; idle_at = cyc + mx1(int'(cfg_trp)); m_pend = 0;
      end else begin
        // last word minus CAS-dependent lead for reads; plus recovery for writes
        if (rd) bst_at = cyc + mx1(cl_n() + bl_n() - 1 - (cl_n() - 1));
        if (wr) bst_at = cyc + mx1(bl_n() - 1 + int'(cfg_tdpl));
        if (pre_req) m_pend = 1;
      end
    end
    cyc++;
  end

  always @(negedge clk) begin
    #2;
    if (m_live && !done) begin
      check("R1 R2 R3 R4 R5 R7 pre_ok", pre_ok, e_ok());
      check("R7 R8 pre_cmd", pre_cmd, e_cmd());
      check("R9 R10 bank_idle", bank_idle, e_idle());
      check("R10 row_open", row_open, e_open());
    end
  end

  task automatic tick();
    @(negedge clk);
    act = 0; rd = 0; wr = 0; pre_req = 0;
  endtask

  task automatic close_row();
    tick(); pre_req = 1;
    repeat (20) begin tick(); if (bank_idle) break; end
    repeat (20) begin if (bank_idle) break; tick(); end
  endtask

  initial begin
    #(5.0 * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1; tick(); tick(); rst = 0;
    #2;
    check("R11 reset bank_idle", bank_idle, 1);
    check("R11 reset row_open", row_open, 0);
    check("R11 reset pre_ok", pre_ok, 0);
    m_live = 1;

    // R3: CL2 BL4, read one clock after activate
    cfg_cl = 2; cfg_bl = 2; cfg_tras = 3; cfg_trp = 2;
    tick(); act = 1;
    tick(); rd = 1;
    for (int k = 1; k <= 6; k++) begin tick(); #2; check("R3 read CL2 window", pre_ok, k >= 4); end
    tick(); pre_req = 1; #2; check("R7 pre_cmd issued", pre_cmd, 1);
    tick(); act = 1; #2;
    check("R9 not idle during tRP", bank_idle, 0);
    check("R9 row closed", row_open, 0);
    tick(); #2;
    check("R9 idle after tRP", bank_idle, 1);
    check("R10 early act ignored", row_open, 0);

    // R4 R6: CL3 BL8
    cfg_cl = 3; cfg_bl = 3; cfg_tras = 2;
    act = 1;
    tick(); rd = 1;
    for (int k = 1; k <= 9; k++) begin tick(); #2; check("R4 R6 read CL3 BL8", pre_ok, k >= 8); end
    close_row();

    // R5 R8: write BL4 tDPL 2, request held from early
    cfg_cl = 2; cfg_bl = 2; cfg_tdpl = 2; cfg_tras = 1;
    act = 1;
    tick(); wr = 1;
    tick(); pre_req = 1; #2; check("R8 early request blocked", pre_cmd, 0);
    for (int k = 2; k <= 5; k++) begin tick(); #2; check("R5 R8 write recovery", pre_cmd, k == 5); end
    repeat (3) tick();

    // R1 R2: tRAS alone
    cfg_tras = 10;
    act = 1;
    for (int k = 1; k <= 11; k++) begin tick(); #2; check("R1 R2 tRAS only", pre_ok, k >= 10); end
    close_row();

    // R12: second read restarts window
    cfg_tras = 1; cfg_bl = 2;
    act = 1;
    tick(); rd = 1;
    tick(); tick(); rd = 1;
    for (int k = 1; k <= 5; k++) begin tick(); #2; check("R12 restart by later read", pre_ok, k >= 4); end
    close_row();

    // R5 R6: BL1 write with zero recovery; R7 request in idle ignored
    cfg_bl = 0; cfg_tdpl = 0;
    pre_req = 1; #2; check("R7 idle request ignored", pre_cmd, 0);
    tick(); #2; check("R7 idle request not held", row_open, 0);
    act = 1;
    tick(); wr = 1;
    tick(); #2; check("R5 R6 BL1 write", pre_ok, 1);
    close_row();

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      tick();
      if (bank_idle && ($urandom % 4 == 0)) begin
        cfg_cl = 2'($urandom % 4); cfg_bl = 2'($urandom % 4);
        cfg_tras = CNT_W'($urandom % 12); cfg_trp = CNT_W'($urandom % 5);
        cfg_tdpl = CNT_W'($urandom % 4);
      end
      rst = ($urandom % 500 == 0);
      act = ($urandom % 4 == 0);
      case ($urandom % 8)
        0: rd = 1;
        1: wr = 1;
        default: ;
      endcase
      pre_req = ($urandom % 5 == 0);
    end
    tick(); rst = 0;
    tick(); tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule